// File: doc/BRIEF.md
# Serial Flash Array Read Responder

This block is the device side of a page-organised serial flash that answers two read commands from the main array over a mode-0 serial link. A host pulls the chip select low and clocks in an 8-bit command and a 24-bit address, most significant bit first, on the rising edges of the serial clock. It then sends 32 filler bits. After that the responder shifts stored bytes back, most significant bit first, changing its output on each falling edge. The address word holds 2 reserved bits, then a 12-bit page number, then a 10-bit starting byte. Each page holds 528 bytes.

The two commands differ only in how the read pointer wraps. The streaming command walks across page boundaries and restarts at page 0 after the last page. The single-page command stays inside the addressed page and returns to its first byte. Any other command makes the responder stay silent until chip select rises. The storage is a behavioural byte array that a testbench fills through a write port. The full part has 4096 pages; here a parameter sets the page count, and the page number is folded into that count. The serial pins are sampled by a faster system clock through synchronisers. A released output pin is shown as `so_en` low.

Top module: `flash_read_resp`

## Requirements
- R1: Command 68h or E8h selects streaming read, and command 52h or D2h selects single-page read; both return data from the array.
- R2: The 24 address bits follow the command, MSB first. Bits 23:22 are ignored, bits 21:10 give the page number (reduced modulo PAGES), and bits 9:0 give the starting byte. All input bits are sampled on SCK rising edges.
- R3: `so_en` stays low through the command, the address and the 32 filler bits. The first data bit is driven on the SCK falling edge that follows the 32nd filler bit.
- R4: Data leaves MSB first, one bit per SCK falling edge, with no gap between consecutive bytes.
- R5: In streaming read, the byte after byte 527 of page p is byte 0 of page p+1.
- R6: In streaming read, the byte after byte 527 of the last page is byte 0 of page 0.
- R7: In single-page read, the byte after byte 527 is byte 0 of the same page.
- R8: While `cs_n` is high, and from reset, `so_en` is low. A rise of `cs_n` ends the read within a few clock cycles, even in the middle of a byte.
- R9: Any other command keeps `so_en` low for the rest of the transaction. The array is unchanged.
- R10: A starting byte of 528 or more begins the read at byte 0 of the addressed page.
- R11: Reads never change the array; repeating a read returns the same bytes.
- R12: A preload write with `pl_we` high stores `pl_data` at linear index page*528+byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | AW (12) | Preload linear byte index |
| pl_data | input | 8 | Preload byte |
| so_data | output | 1 | Serial data out |
| so_en | output | 1 | Output drive enable; low means high impedance |

## Verification
The assertions hold on every cycle for these rules: the output is enabled only in the data phase and never after an unknown command; chip select high clears the data phase; the output bit moves only on a falling SCK edge; the byte pointer stays below 528; the page stays fixed in single-page mode; and the page and array wrap steps are correct in streaming mode. Only the bench scenarios can show the rest. They check that the bytes arriving at the pin are the right stored bytes in the right order: address field placement, reserved-bit and page folding, start-byte clamping, a break in mid-byte, and repeated reads that prove the array is unchanged.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } rd_state_e;

  typedef enum logic {
    MODE_CONT = 1'b0,
    MODE_PAGE = 1'b1
  } rd_mode_e;

  typedef struct packed {
    logic     ok;
    rd_mode_e mode;
  } op_dec_t;

  // Command byte to read mode.
  function automatic op_dec_t decode_op(logic [7:0] op);
    op_dec_t d;
    d.ok   = 1'b1;
    d.mode = MODE_CONT;
    case (op)
      8'h68, 8'hE8: d.mode = MODE_CONT;
      8'h52, 8'hD2: d.mode = MODE_PAGE;
      default:      d.ok   = 1'b0;
    endcase
    return d;
  endfunction

  // Out-of-range start byte restarts at zero.
  function automatic logic [9:0] clamp_byte(logic [9:0] b, int unsigned n);
    return (32'(b) >= n) ? 10'd0 : b;
  endfunction

  // Byte step inside a page.
  function automatic logic [9:0] next_byte(logic [9:0] b, int unsigned n);
    return (32'(b) == n - 1) ? 10'd0 : b + 10'd1;
  endfunction

  // Page field folded into the configured page count.
  function automatic logic [11:0] fold_page(logic [11:0] p, int unsigned n);
    return 12'(32'(p) % n);
  endfunction

  // Page step for streaming mode.
  function automatic int unsigned next_page(int unsigned p, int unsigned n);
    return (p == n - 1) ? 0 : p + 1;
  endfunction

  function automatic int unsigned lin_index(int unsigned pg, int unsigned by,
                                            int unsigned n);
    return pg * n + by;
  endfunction

endpackage

// File: rtl/flash_rd_sync.sv
module flash_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] raw,       // {si, cs_n, sck}
  output logic [2:0] synced,
  output logic       sck_rise,
  output logic       sck_fall
);
  localparam logic [2:0] RST_VAL = 3'b010;  // chip select idles high

  logic sck_prev;

  for (genvar g = 0; g < 3; g++) begin : g_pin
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL[g]}};
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign synced[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= synced[0];
  end

  assign sck_rise = synced[0] & ~sck_prev;
  assign sck_fall = ~synced[0] & sck_prev;
endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
  import flash_rd_pkg::*;
#(
  parameter int OPC_BITS   = 8,
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n_s,
  input  logic                 si_s,
  input  logic                 sck_rise,
  output rd_state_e            state,
  output rd_mode_e             mode,
  output logic [ADDR_BITS-1:0] addr_word,
  output logic                 load_go,
  output logic                 in_data,
  output logic                 in_skip
);
  localparam int MAXB = (ADDR_BITS > DUMMY_BITS) ? ADDR_BITS : DUMMY_BITS;
  localparam int CW   = $clog2(MAXB + 1);

  logic [CW-1:0]        cnt;
  logic [ADDR_BITS-1:0] sh;
  logic [ADDR_BITS-1:0] sh_next;
  op_dec_t              dec;
  logic                 opc_last, addr_last, dummy_last;

  assign sh_next    = {sh[ADDR_BITS-2:0], si_s};
  assign dec        = decode_op(sh_next[OPC_BITS-1:0]);
  assign opc_last   = (cnt == CW'(OPC_BITS - 1));
  assign addr_last  = (cnt == CW'(ADDR_BITS - 1));
  assign dummy_last = (cnt == CW'(DUMMY_BITS - 1));

  assign load_go = !cs_n_s && (state == ST_DUMMY) && sck_rise && dummy_last;
  assign in_data = (state == ST_DATA);
  assign in_skip = (state == ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode      <= MODE_CONT;
      cnt       <= '0;
      sh        <= '0;
      addr_word <= '0;
    end else if (cs_n_s) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          state <= ST_OPC;
          cnt   <= '0;
        end
        ST_OPC: if (sck_rise) begin
          sh <= sh_next;
          if (opc_last) begin
            cnt   <= '0;
            mode  <= dec.mode;
            state <= dec.ok ? ST_ADDR : ST_SKIP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_ADDR: if (sck_rise) begin
          sh <= sh_next;
          if (addr_last) begin
            cnt       <= '0;
            addr_word <= sh_next;
            state     <= ST_DUMMY;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DUMMY: if (sck_rise) begin
          if (dummy_last) begin
            cnt   <= '0;
            state <= ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= state;  // data and skip hold until deselect
      endcase
    end
  end
endmodule

// File: rtl/flash_rd_addr.sv
module flash_rd_addr
  import flash_rd_pkg::*;
#(
  parameter int PAGE_BYTES = 528,
  parameter int PAGES      = 4,
  parameter int PW         = (PAGES > 1) ? $clog2(PAGES) : 1,
  parameter int AW         = $clog2(PAGE_BYTES * PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [23:0]   addr_word,
  input  logic          step,
  input  rd_mode_e      mode,
  output logic [PW-1:0] cur_page,
  output logic [9:0]    cur_byte,
  output logic [AW-1:0] lin
);
  logic byte_last;
  assign byte_last = (32'(cur_byte) == PAGE_BYTES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_page <= '0;
      cur_byte <= '0;
    end else if (load) begin
      cur_page <= PW'(fold_page(addr_word[21:10], PAGES));
      cur_byte <= clamp_byte(addr_word[9:0], PAGE_BYTES);
    end else if (step) begin
      cur_byte <= next_byte(cur_byte, PAGE_BYTES);
      if (byte_last && mode == MODE_CONT)
        cur_page <= PW'(next_page(32'(cur_page), PAGES));
    end
  end

  assign lin = AW'(lin_index(32'(cur_page), 32'(cur_byte), PAGE_BYTES));
endmodule

// File: rtl/flash_rd_mem.sv
module flash_rd_mem #(
  parameter int TOTAL = 2112,
  parameter int AW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  logic [7:0] arr [TOTAL];

  always_ff @(posedge clk) begin
    if (we && 32'(wa) < TOTAL) arr[wa] <= wd;
  end

  assign rd = arr[ra];
endmodule

// File: rtl/flash_read_resp.sv
module flash_read_resp
  import flash_rd_pkg::*;
#(
  parameter int PAGE_BYTES  = 528,
  parameter int PAGES       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int TOTAL       = PAGE_BYTES * PAGES,
  parameter int AW          = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          si,
  input  logic          pl_we,
  input  logic [AW-1:0] pl_addr,
  input  logic [7:0]    pl_data,
  output logic          so_data,
  output logic          so_en
);
  localparam int PW = (PAGES > 1) ? $clog2(PAGES) : 1;

  logic [2:0]    pins_s;
  logic          sck_rise, sck_fall, cs_n_s, si_s;
  rd_state_e     state;
  rd_mode_e      mode;
  logic [23:0]   addr_word;
  logic          load_go, in_data, in_skip, addr_step, mode_page;
  logic [PW-1:0] cur_page;
  logic [9:0]    cur_byte;
  logic [AW-1:0] lin;
  logic [7:0]    mem_byte;
  logic [2:0]    bit_ptr;

  flash_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({si, cs_n, sck}), .synced(pins_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall)
  );
  assign cs_n_s = pins_s[1];
  assign si_s   = pins_s[2];

  flash_rd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .si_s(si_s),
    .sck_rise(sck_rise), .state(state), .mode(mode), .addr_word(addr_word),
    .load_go(load_go), .in_data(in_data), .in_skip(in_skip)
  );
  assign mode_page = (mode == MODE_PAGE);

  flash_rd_addr #(.PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .PW(PW), .AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load_go), .addr_word(addr_word),
    .step(addr_step), .mode(mode), .cur_page(cur_page), .cur_byte(cur_byte),
    .lin(lin)
  );

  flash_rd_mem #(.TOTAL(TOTAL), .AW(AW)) u_mem (
    .clk(clk), .we(pl_we), .wa(pl_addr), .wd(pl_data), .ra(lin), .rd(mem_byte)
  );

  // Output serializer: one bit per SCK falling edge, byte pointer advance on bit 0.
  assign addr_step = in_data & sck_fall & (bit_ptr == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_data <= 1'b0;
      so_en   <= 1'b0;
      bit_ptr <= 3'd0;
    end else if (!in_data) begin
      so_en   <= 1'b0;
      bit_ptr <= 3'd0;
    end else if (sck_fall) begin
      so_data <= mem_byte[3'd7 - bit_ptr];
      so_en   <= 1'b1;
      bit_ptr <= bit_ptr + 3'd1;
    end
  end
endmodule

// File: rtl/flash_read_resp_chk.sv
module flash_read_resp_chk #(
  parameter int PAGE_BYTES = 528,
  parameter int PAGES      = 4,
  parameter int PW         = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n_s,
  input logic          sck_fall,
  input logic          in_data,
  input logic          in_skip,
  input logic          so_en,
  input logic          so_data,
  input logic          addr_step,
  input logic          mode_page,
  input logic [PW-1:0] cur_page,
  input logic [9:0]    cur_byte
);
  // R3: output released outside the data phase
  p_oe_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_data |=> !so_en);

  // R8: deselect leaves the data phase
  p_cs_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> !in_data);

  // R9: unknown command never drives the pin
  p_skip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> !so_en);

  // R4: output bit moves only on a falling SCK edge
  p_so_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_fall |=> $stable(so_data));

  // R10: byte pointer never leaves the page
  p_byte_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (32'(cur_byte) < PAGE_BYTES));

  // R7: single-page read keeps its page
  p_page_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && mode_page && $past(in_data)) |-> cur_page == $past(cur_page));

  // R5: streaming read crosses into the next page
  p_page_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_step && !mode_page && 32'(cur_byte) == PAGE_BYTES - 1 &&
     32'(cur_page) != PAGES - 1)
    |=> (cur_byte == 10'd0 && cur_page == PW'($past(cur_page) + 1'b1)));

  // R6: streaming read wraps at the end of the array
  p_array_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_step && !mode_page && 32'(cur_byte) == PAGE_BYTES - 1 &&
     32'(cur_page) == PAGES - 1)
    |=> (cur_byte == 10'd0 && cur_page == '0));
endmodule

bind flash_read_resp flash_read_resp_chk #(
  .PAGE_BYTES(PAGE_BYTES), .PAGES(PAGES), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sck_fall(sck_fall),
  .in_data(in_data), .in_skip(in_skip), .so_en(so_en), .so_data(so_data),
  .addr_step(addr_step), .mode_page(mode_page), .cur_page(cur_page),
  .cur_byte(cur_byte)
);

// File: tb/flash_read_resp_tb.sv
module flash_read_resp_tb;
  localparam int PB  = 528;
  localparam int NP  = 4;
  localparam int TOT = PB * NP;
  localparam int AW  = $clog2(TOT);

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic pl_we = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0] pl_data = '0;
  logic so_data, so_en;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic mon_on = 1'b0;

  always #2 clk = ~clk;

  flash_read_resp u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .so_data(so_data), .so_en(so_en)
  );

  function automatic logic [7:0] pat(int i);
    return 8'(((i * 13) + (i >> 4)) ^ 8'h5a);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic bit_out(logic b);
    si = b;
    half();
    sck = 1'b1;
    half();
    sck = 1'b0;
  endtask

  // Driver: pushes expected bytes from its own model, then runs the wire protocol.
  task automatic xfer(logic [7:0] op, int pg, int by, logic [1:0] rsv,
                      int nbytes, int extra, bit valid, bit cont, string tag);
    logic [31:0] w;
    int p, b;
    bit quiet;
    p = pg % NP;
    b = (by >= PB) ? 0 : by;
    if (valid) begin
      for (int k = 0; k < nbytes; k++) begin
        exp_q.push_back(pat(p * PB + b));
        tag_q.push_back(tag);
        b++;
        if (b == PB) begin
          b = 0;
          if (cont) p = (p + 1) % NP;
        end
      end
    end
    w = {op, rsv, pg[11:0], by[9:0]};
    cs_n = 1'b0;
    half();
    for (int i = 31; i >= 0; i--) bit_out(w[i]);
    for (int i = 0; i < 31; i++) bit_out(i[0]);
    si = 1'b1;
    half();
    sck = 1'b1;
    half();
    check(so_en === 1'b0, {"R3 header quiet ", tag}, so_en, 0);
    sck = 1'b0;
    quiet = 1'b1;
    if (valid) mon_on = 1'b1;
    for (int i = 0; i < nbytes * 8; i++) begin
      bit_out(1'b0);
      if (so_en !== 1'b0) quiet = 1'b0;
    end
    mon_on = 1'b0;
    if (!valid) check(quiet, {"R9 unknown command quiet ", tag}, !quiet, 0);
    for (int i = 0; i < extra; i++) bit_out(1'b0);
    half();
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    check(so_en === 1'b0, {"R8 released after deselect ", tag}, so_en, 0);
    half();
  endtask

  // Monitor: assembles bytes at SCK rising edges and compares with the queue.
  initial begin
    logic [7:0] acc = '0;
    int n = 0;
    logic [7:0] e;
    string t;
    forever begin
      @(posedge sck);
      if (mon_on) begin
        acc = {acc[6:0], so_data};
        n++;
        if (n == 8) begin
          n = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R4 unexpected byte", acc, 0);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(acc === e && so_en === 1'b1, t, acc, e);
          end
        end
      end else begin
        n = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R4 actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(so_en === 1'b0, "R8 reset so_en", so_en, 0);
    check(so_data === 1'b0, "R8 reset so_data", so_data, 0);
    rst_n = 1'b1;
    // R12: preload every linear index through the write port
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk);
      pl_we = 1'b1;
      pl_addr = AW'(i);
      pl_data = pat(i);
    end
    @(negedge clk);
    pl_we = 1'b0;
    repeat (4) @(negedge clk);

    xfer(8'h68, 1, 10, 2'b00, 4, 0, 1, 1, "R1 R12 streaming basic");
    xfer(8'hE8, 0, 526, 2'b00, 4, 0, 1, 1, "R5 page crossing");
    xfer(8'h68, 3, 526, 2'b00, 4, 0, 1, 1, "R6 array wrap");
    xfer(8'h52, 2, 525, 2'b00, 5, 0, 1, 0, "R7 page wrap");
    xfer(8'hD2, 1, 527, 2'b00, 3, 0, 1, 0, "R7 page wrap alt command");
    xfer(8'h68, 1, 700, 2'b00, 2, 0, 1, 1, "R10 start clamp");
    xfer(8'hD2, 2, 528, 2'b00, 2, 0, 1, 0, "R10 start clamp page mode");
    xfer(8'hE8, 6, 3, 2'b11, 3, 0, 1, 1, "R2 reserved bits and fold");
    xfer(8'h52, 4095, 100, 2'b10, 2, 0, 1, 0, "R2 top page number");
    xfer(8'h54, 1, 10, 2'b00, 2, 0, 0, 0, "R9 unknown 54h");
    xfer(8'h00, 0, 0, 2'b00, 1, 0, 0, 0, "R9 unknown 00h");
    xfer(8'h68, 0, 200, 2'b00, 1, 3, 1, 1, "R8 mid-byte abort");
    xfer(8'h68, 0, 201, 2'b00, 2, 0, 1, 1, "R8 read after abort");
    xfer(8'h68, 1, 10, 2'b00, 4, 0, 1, 1, "R11 repeat read unchanged");
    xfer(8'h52, 2, 525, 2'b00, 5, 0, 1, 0, "R11 repeat page read unchanged");

    check(exp_q.size() == 0, "R4 all bytes delivered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule